// File: doc/BRIEF.md
# CAN Error Report Supervisor

This block sits next to a CAN protocol controller and turns the controller's error status into short report frames. On each error interrupt it captures the six condition flags (receive overflow, receive warning, transmit warning, receive error-passive, transmit error-passive, bus-off) into a pending set. It then asks the transmit path for one report frame per condition, one at a time. Every frame uses identifier 0x3FF and carries a single code byte. An interrupt that names neither a receive nor an error cause counts as a system fault and is reported too.

Bus-off is handled with a two-strike policy. On the first bus-off the supervisor pulses a re-initialise request to the controller. It then sends code 0x12 and waits for the transmit result. If the frame goes out, the supervisor records that a bus-off has been seen and carries on. If the frame fails, or a bus-off arrives after one has already been seen (reported once as code 0x13), the node enters a halted state. In that state it issues no further requests, and only reset clears it.

The transmit side answers each request with a one-cycle `txDone` (success) or `txFail` (failure). The supervisor holds the request until one of them arrives.

Top module: `can_err_supervisor`

## Requirements
- R1: Every report request presents identifier 0x3FF on `txId` together with one code byte on `txCode`.
- R2: An error interrupt with the overflow flag (`errFlags[0]`) set produces a report with code 0x11.
- R3: The warning and error-passive flags map to these codes: receive warning (`errFlags[1]`) to 0x01, transmit warning (`errFlags[2]`) to 0x02, receive error-passive (`errFlags[3]`) to 0x03, transmit error-passive (`errFlags[4]`) to 0x04.
- R4: When several conditions are pending, one report is sent per condition in this order: overflow, receive warning, transmit warning, receive passive, transmit passive, invalid interrupt, bus-off.
- R5: `txReq` stays high with a stable `txCode` until `txDone` or `txFail` is seen. It drops in the cycle after the result.
- R6: On the first bus-off (`errFlags[5]`), `ctrlReinit` pulses for exactly one cycle. In the next cycle `txReq` rises with code 0x12.
- R7: If the 0x12 report completes with `txDone`, the node is not halted, and later error interrupts are reported normally.
- R8: If the 0x12 report completes with `txFail`, `halted` rises in the cycle after the result.
- R9: A bus-off after a successful recovery is reported with code 0x13, with no `ctrlReinit`. `halted` rises in the cycle after that report's result.
- R10: While `halted` is high, `txReq` and `ctrlReinit` stay low whatever the inputs do, and `halted` stays high until reset.
- R11: An interrupt strobe with neither `irqRxCause` nor `irqErrCause` set produces a report with code 0x20. A strobe with only `irqRxCause` set produces no report.
- R12: After reset, `txReq`, `ctrlReinit` and `halted` are all low.
- R13: `errFlags` is sampled only on a strobe with `irqErrCause` set. Flags present without that cause produce no report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irqStrobe | input | 1 | One-cycle interrupt event from the controller |
| irqRxCause | input | 1 | Interrupt carries a receive cause |
| irqErrCause | input | 1 | Interrupt carries an error cause |
| errFlags | input | 6 | Condition flags: [0] overflow, [1] rx warn, [2] tx warn, [3] rx passive, [4] tx passive, [5] bus-off |
| txDone | input | 1 | Current report frame was sent |
| txFail | input | 1 | Current report frame failed |
| txReq | output | 1 | Report frame request, held until a result |
| txId | output | 11 | Report identifier (0x3FF) |
| txCode | output | 8 | Report code byte |
| ctrlReinit | output | 1 | One-cycle controller re-initialise request |
| halted | output | 1 | Node permanently idle until reset |

## Verification
A pending bit that is lost or left set shows up at the ports as a missing or repeated code. This is visible within a couple of cycles after the previous report's result, so the bench answers each request and checks the next code in priority order. A wrong bus-off-seen flag shows within two cycles of a bus-off interrupt: a `ctrlReinit` pulse and code 0x12 where 0x13 was due, or the reverse. A wrong halt state shows as a request while `halted` is high, or as `halted` missing in the cycle after a failed recovery or a final 0x13 report.

// File: rtl/errsup_pkg.sv
package errsup_pkg;
  localparam int FLAG_W   = 6;
  localparam int NUM_SRC  = 7;
  localparam int IDX_W    = $clog2(NUM_SRC);
  localparam int CODE_W   = 8;
  localparam int ID_W     = 11;
  localparam logic [ID_W-1:0] REPORT_ID = 11'h3FF;

  // pending-slot positions, lowest index served first
  localparam int SRC_OVF     = 0;
  localparam int SRC_RXWARN  = 1;
  localparam int SRC_TXWARN  = 2;
  localparam int SRC_RXPASS  = 3;
  localparam int SRC_TXPASS  = 4;
  localparam int SRC_INVALID = 5;
  localparam int SRC_BUSOFF  = 6;
  localparam int FLAG_BUSOFF = 5;

  typedef enum logic [1:0] {ST_IDLE, ST_REINIT, ST_SEND, ST_HALT} state_t;
  typedef enum logic [1:0] {KIND_PLAIN, KIND_RECOVER, KIND_FINAL} kind_t;

  typedef struct packed {
    logic take;      // latch code of selected slot and clear it
    logic markSeen;  // recovery report went out
    logic freeze;    // halted: drop and ignore everything
  } ctlStrobe_t;

  typedef struct packed {
    logic anyPending;
    logic selBusOff;
    logic seen;
  } dpStatus_t;

  function automatic logic [CODE_W-1:0] codeFor(input logic [IDX_W-1:0] idx, input logic seen);
    case (idx)
      IDX_W'(SRC_OVF):     codeFor = 8'h11;
      IDX_W'(SRC_RXWARN):  codeFor = 8'h01;
      IDX_W'(SRC_TXWARN):  codeFor = 8'h02;
      IDX_W'(SRC_RXPASS):  codeFor = 8'h03;
      IDX_W'(SRC_TXPASS):  codeFor = 8'h04;
      IDX_W'(SRC_INVALID): codeFor = 8'h20;
      default:             codeFor = seen ? 8'h13 : 8'h12;
    endcase
  endfunction
endpackage

// File: rtl/errsup_dp.sv
module errsup_dp
  import errsup_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irqStrobe,
  input  logic              irqRxCause,
  input  logic              irqErrCause,
  input  logic [FLAG_W-1:0] errFlags,
  input  ctlStrobe_t        ctl,
  output dpStatus_t         status,
  output logic [CODE_W-1:0] curCode
);
  logic [NUM_SRC-1:0] pending;
  logic [NUM_SRC-1:0] newBits;
  logic [NUM_SRC-1:0] clearMask;
  logic [IDX_W-1:0]   selIdx;
  logic               found;
  logic               seen;
  logic               errEvent;

  assign errEvent = irqStrobe && irqErrCause;

  genvar g;
  generate
    for (g = 0; g < SRC_INVALID; g++) begin : g_flagMap
      assign newBits[g] = errEvent && errFlags[g];
    end
  endgenerate
  assign newBits[SRC_INVALID] = irqStrobe && !irqRxCause && !irqErrCause;
  assign newBits[SRC_BUSOFF]  = errEvent && errFlags[FLAG_BUSOFF];

  always_comb begin
    selIdx = '0;
    found  = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pending[i] && !found) begin
        selIdx = IDX_W'(i);
        found  = 1'b1;
      end
    end
  end

  assign clearMask = ctl.take ? (NUM_SRC'(1) << selIdx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || ctl.freeze) begin
      pending <= '0;
    end else begin
      pending <= (pending & ~clearMask) | newBits;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen    <= 1'b0;
      curCode <= '0;
    end else begin
      if (ctl.markSeen) seen <= 1'b1;
      if (ctl.take)     curCode <= codeFor(selIdx, seen);
    end
  end

  assign status.anyPending = found;
  assign status.selBusOff  = (selIdx == IDX_W'(SRC_BUSOFF));
  assign status.seen       = seen;
endmodule

// File: rtl/errsup_ctl.sv
module errsup_ctl
  import errsup_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  dpStatus_t  status,
  input  logic       txDone,
  input  logic       txFail,
  output ctlStrobe_t ctl,
  output logic       txReq,
  output logic       ctrlReinit,
  output logic       halted
);
  state_t state, nextState;
  kind_t  kind, nextKind;
  logic   result, success;

  assign result  = txDone || txFail;
  assign success = txDone && !txFail;

  always_comb begin
    nextState    = state;
    nextKind     = kind;
    ctl.take     = 1'b0;
    ctl.markSeen = 1'b0;
    ctl.freeze   = (state == ST_HALT);
    case (state)
      ST_IDLE: begin
        if (status.anyPending) begin
          ctl.take = 1'b1;
          if (status.selBusOff && !status.seen) begin
            nextState = ST_REINIT;
            nextKind  = KIND_RECOVER;
          end else begin
            nextState = ST_SEND;
            nextKind  = status.selBusOff ? KIND_FINAL : KIND_PLAIN;
          end
        end
      end
      ST_REINIT: nextState = ST_SEND;
      ST_SEND: begin
        if (result) begin
          case (kind)
            KIND_RECOVER: begin
              if (success) begin
                ctl.markSeen = 1'b1;
                nextState    = ST_IDLE;
              end else begin
                nextState = ST_HALT;
              end
            end
            KIND_FINAL: nextState = ST_HALT;
            default:    nextState = ST_IDLE;
          endcase
        end
      end
      default: nextState = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      kind  <= KIND_PLAIN;
    end else begin
      state <= nextState;
      kind  <= nextKind;
    end
  end

  assign txReq      = (state == ST_SEND);
  assign ctrlReinit = (state == ST_REINIT);
  assign halted     = (state == ST_HALT);
endmodule

// File: rtl/can_err_supervisor.sv
module can_err_supervisor
  import errsup_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irqStrobe,
  input  logic              irqRxCause,
  input  logic              irqErrCause,
  input  logic [FLAG_W-1:0] errFlags,
  input  logic              txDone,
  input  logic              txFail,
  output logic              txReq,
  output logic [ID_W-1:0]   txId,
  output logic [CODE_W-1:0] txCode,
  output logic              ctrlReinit,
  output logic              halted
);
  ctlStrobe_t ctl;
  dpStatus_t  status;

  errsup_dp u_dp (
    .clk(clk), .rst_n(rst_n),
    .irqStrobe(irqStrobe), .irqRxCause(irqRxCause), .irqErrCause(irqErrCause),
    .errFlags(errFlags), .ctl(ctl), .status(status), .curCode(txCode)
  );

  errsup_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .status(status),
    .txDone(txDone), .txFail(txFail), .ctl(ctl),
    .txReq(txReq), .ctrlReinit(ctrlReinit), .halted(halted)
  );

  assign txId = REPORT_ID;
endmodule

// File: rtl/errsup_checker.sv
module errsup_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       txDone,
  input logic       txFail,
  input logic       txReq,
  input logic [7:0] txCode,
  input logic       ctrlReinit,
  input logic       halted
);
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted); // R10
  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!txReq && !ctrlReinit)); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (txReq && !txDone && !txFail) |=> (txReq && $stable(txCode))); // R5
  AST_REINIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlReinit |=> !ctrlReinit); // R6
  AST_REINIT_THEN_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlReinit |=> (txReq && txCode == 8'h12)); // R6
  AST_RECOVER_FAIL_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (txReq && txCode == 8'h12 && txFail) |=> halted); // R8
  AST_FINAL_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (txReq && txCode == 8'h13 && (txDone || txFail)) |=> halted); // R9
endmodule

bind can_err_supervisor errsup_checker u_chk (
  .clk(clk), .rst_n(rst_n), .txDone(txDone), .txFail(txFail),
  .txReq(txReq), .txCode(txCode), .ctrlReinit(ctrlReinit), .halted(halted)
);

// File: tb/sim_can_err_supervisor.sv
module sim_can_err_supervisor;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irqStrobe = 1'b0, irqRxCause = 1'b0, irqErrCause = 1'b0;
  logic [5:0] errFlags = '0;
  logic txDone = 1'b0, txFail = 1'b0;
  logic txReq, ctrlReinit, halted;
  logic [10:0] txId;
  logic [7:0] txCode;
  int tests = 0, fails = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_err_supervisor u0 (
    .clk(clk), .rst_n(rst_n), .irqStrobe(irqStrobe), .irqRxCause(irqRxCause),
    .irqErrCause(irqErrCause), .errFlags(errFlags), .txDone(txDone), .txFail(txFail),
    .txReq(txReq), .txId(txId), .txCode(txCode), .ctrlReinit(ctrlReinit), .halted(halted)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=<50000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    tests++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulseIrq(input bit rx, input bit err, input logic [5:0] fl);
    irqStrobe = 1'b1; irqRxCause = rx; irqErrCause = err; errFlags = fl;
    @(negedge clk);
    irqStrobe = 1'b0; irqRxCause = 1'b0; irqErrCause = 1'b0; errFlags = '0;
  endtask

  task automatic answer(input bit ok);
    txDone = ok; txFail = !ok;
    @(negedge clk);
    txDone = 1'b0; txFail = 1'b0;
  endtask

  // wait for a request, check id and code, answer it
  task automatic expectReport(input logic [7:0] exp, input string tag, input bit ok);
    int n = 0;
    while (!txReq && n < 30) begin @(negedge clk); n++; end
    chk(txReq == 1'b1, {tag, " request seen"}, txReq, 1);
    chk(txId == 11'h3FF, "R1 report id", txId, 11'h3FF);
    chk(txCode == exp, tag, txCode, exp);
    answer(ok);
  endtask

  task automatic expectQuiet(input int n, input string tag);
    bit saw = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (txReq || ctrlReinit) saw = 1'b1;
    end
    chk(!saw, tag, saw, 0);
  endtask

  task automatic t_reset();
    chk(!txReq && !ctrlReinit && !halted, "R12 reset outputs idle",
        {txReq, ctrlReinit, halted}, 0);
  endtask

  task automatic t_overflow();
    pulseIrq(1'b0, 1'b1, 6'b000001);
    expectReport(8'h11, "R2 overflow code", 1'b1);
    expectQuiet(5, "R2 single report per flag");
  endtask

  task automatic t_priority();
    pulseIrq(1'b0, 1'b1, 6'b011111);
    expectReport(8'h11, "R4 first overflow", 1'b1);
    expectReport(8'h01, "R3 rx warning 0x01", 1'b1);
    expectReport(8'h02, "R3 tx warning 0x02", 1'b0);
    expectReport(8'h03, "R3 rx passive 0x03", 1'b1);
    expectReport(8'h04, "R3 tx passive 0x04", 1'b1);
    expectQuiet(5, "R4 no extra report");
  endtask

  task automatic t_hold();
    int n = 0;
    logic [7:0] c0;
    pulseIrq(1'b0, 1'b1, 6'b000100);
    while (!txReq && n < 30) begin @(negedge clk); n++; end
    c0 = txCode;
    repeat (6) @(negedge clk);
    chk(txReq && txCode == c0, "R5 request held until result", {txReq, txCode}, {1'b1, c0});
    answer(1'b1);
    chk(!txReq, "R5 request drops after result", txReq, 0);
  endtask

  task automatic t_invalid();
    pulseIrq(1'b0, 1'b0, 6'b000000);
    expectReport(8'h20, "R11 invalid interrupt code", 1'b1);
    pulseIrq(1'b1, 1'b0, 6'b000000);
    expectQuiet(6, "R11 receive-only interrupt silent");
  endtask

  task automatic t_noCause();
    pulseIrq(1'b1, 1'b0, 6'b111111);
    expectQuiet(6, "R13 flags without error cause ignored");
  endtask

  task automatic t_firstBusOff(input bit ok);
    int n = 0;
    pulseIrq(1'b0, 1'b1, 6'b100000);
    while (!ctrlReinit && n < 10) begin @(negedge clk); n++; end
    chk(ctrlReinit && !txReq, "R6 reinit pulse", ctrlReinit, 1);
    @(negedge clk);
    chk(!ctrlReinit && txReq && txCode == 8'h12, "R6 0x12 after reinit",
        {ctrlReinit, txReq, txCode}, {1'b0, 1'b1, 8'h12});
    answer(ok);
    if (ok) chk(!halted, "R7 resumes after recovery", halted, 0);
    else    chk(halted, "R8 failed recovery halts", halted, 1);
  endtask

  task automatic t_afterRecovery();
    pulseIrq(1'b0, 1'b1, 6'b001000);
    expectReport(8'h03, "R7 normal report after recovery", 1'b1);
  endtask

  task automatic t_secondBusOff();
    bit sawReinit = 1'b0;
    int n = 0;
    pulseIrq(1'b0, 1'b1, 6'b100000);
    while (!txReq && n < 30) begin
      if (ctrlReinit) sawReinit = 1'b1;
      @(negedge clk); n++;
    end
    chk(!sawReinit, "R9 no reinit on second bus-off", sawReinit, 0);
    chk(txReq && txCode == 8'h13, "R9 code 0x13", txCode, 8'h13);
    answer(1'b1);
    chk(halted, "R9 halted after final report", halted, 1);
  endtask

  task automatic t_halted();
    pulseIrq(1'b0, 1'b1, 6'b111111);
    pulseIrq(1'b0, 1'b0, 6'b000000);
    expectQuiet(10, "R10 halted suppresses requests");
    chk(halted, "R10 halted sticky", halted, 1);
    doReset();
    chk(!halted && !txReq, "R10 reset clears halt", {halted, txReq}, 0);
  endtask

  initial begin
    doReset();
    t_reset();
    t_overflow();
    t_priority();
    t_hold();
    t_invalid();
    t_noCause();
    t_firstBusOff(1'b1);
    t_afterRecovery();
    t_secondBusOff();
    t_halted();
    t_firstBusOff(1'b0);
    expectQuiet(5, "R8 halted after failed recovery quiet");
    doReset();
    t_reset();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule